// File: doc/BRIEF.md
# Fabric Superframe Packer and Reorderer

This block has two halves that sit on either side of a multi-lane switch fabric. The ingress half takes one unicast packet per cycle, each carrying a destination tag. It gathers consecutive packets for the same destination into a superframe and stamps the superframe with that destination's next sequence number. It then sends the superframe on one of the fabric lanes, picking lanes in rotation. A multicast packet skips the gathering step and crosses the fabric alone, with no sequence number.

The egress half takes superframes from every lane. Because frames on different lanes may overtake each other, it holds them in a small window indexed by sequence number. It unpacks them in sequence order, one packet per cycle. If a missing sequence number never arrives, the egress half gives up on it after a timeout, moves past it and counts the loss.

The number of lanes in use depends on the peer endpoint, so it is an input and may be smaller than the number of lanes built.

Top module: `sf_pack_reorder`

## Requirements
- R1: Consecutive unicast packets with the same destination are placed in one superframe. The first packet occupies payload bits [PKT_W-1:0], the next occupies the following PKT_W bits, and unused slots are zero.
- R2: An open superframe is closed when a unicast packet arrives that would make it exceed MAX_PKTS packets, or that has a different destination. That packet opens the next superframe. The closed frame appears on the lane outputs in the cycle after the clock edge that sampled the closing packet, and lo_cnt gives its packet count (1..MAX_PKTS).
- R3: If a superframe is open and no packet is presented on the edge after it has waited FLUSH_T edges since it opened, it is closed and sent.
- R4: Each destination has its own sequence counter. It starts at 0 after reset and advances by one modulo 2^SEQ_W for each unicast superframe sent to that destination.
- R5: A multicast packet (in_mcast=1) is sent at once as its own frame, with lo_mcast=1, lo_cnt=1 and lo_seq=0. It consumes no sequence number and leaves the open superframe untouched. A flush that falls due on a multicast cycle waits for the next cycle without one.
- R6: At most one frame leaves per cycle, and lo_valid is one-hot. Lanes are taken in rotation 0,1,2,…, wrapping after the last active lane. Multicast frames also advance the rotation.
- R7: act_lanes gives the active lane count. A value of 0 counts as 1, and values above LANES count as LANES. If the rotation pointer is not below the active count, the frame goes on lane 0.
- R8: Egress accepts a unicast lane frame only when (seq − expected) mod 2^SEQ_W is below WIN and that sequence number is not already held. Stale, out-of-window and duplicate frames are discarded.
- R9: Held superframes are released in sequence order, one packet per cycle, lowest slot first, with their destination on out_dest. A frame accepted on one edge can start releasing on the next edge.
- R10: Lane input frames flagged multicast never enter the reorder window and produce no output.
- R11: When the expected sequence number is missing but other frames are held for GAP_T consecutive cycles, the expected number is skipped and skip_cnt increments by one. A frame for that number arriving on the skip edge is discarded.
- R12: While rst_n is low, lo_valid, out_valid and skip_cnt are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Ingress packet present |
| in_mcast | input | 1 | Ingress packet is multicast |
| in_dest | input | DEST_W | Ingress destination tag |
| in_data | input | PKT_W | Ingress packet word |
| act_lanes | input | $clog2(LANES+1) | Number of active lanes |
| lo_valid | output | LANES | One-hot lane strobe for the outgoing frame |
| lo_mcast | output | 1 | Outgoing frame is multicast |
| lo_dest | output | DEST_W | Outgoing frame destination |
| lo_seq | output | SEQ_W | Outgoing frame sequence number |
| lo_cnt | output | $clog2(MAX_PKTS+1) | Packets in outgoing frame |
| lo_data | output | MAX_PKTS*PKT_W | Outgoing frame payload |
| li_valid | input | LANES | Per-lane incoming frame strobe |
| li_mcast | input | LANES | Per-lane multicast flag |
| li_dest | input | LANES*DEST_W | Per-lane destination |
| li_seq | input | LANES*SEQ_W | Per-lane sequence number |
| li_cnt | input | LANES*$clog2(MAX_PKTS+1) | Per-lane packet count |
| li_data | input | LANES*MAX_PKTS*PKT_W | Per-lane payload |
| out_valid | output | 1 | Released packet present |
| out_dest | output | DEST_W | Released packet destination |
| out_data | output | PKT_W | Released packet word |
| skip_cnt | output | 16 | Count of skipped sequence numbers |

## Verification
The bench builds the block with four lanes, four-packet frames, a 4-bit sequence space with a window of 4, a flush timeout of 5 and a gap timeout of 10. The small sequence space makes every destination's counter, and the egress expected number, wrap several times within a short run. The short timeouts let both the flush path and repeated gap skips occur inside directed scenes. The window of 4 means that random bursts of out-of-order frames regularly hit the window edge and the duplicate filter, and that switching act_lanes between 4, 3, 1 and 0 exercises rotation wrap and the fallback to lane 0.

// File: rtl/sf_pack_reorder.sv
module sf_pack_reorder #(
  parameter int PKT_W    = 8,
  parameter int MAX_PKTS = 4,
  parameter int DEST_W   = 2,
  parameter int LANES    = 4,
  parameter int SEQ_W    = 4,
  parameter int WIN      = 4,
  parameter int FLUSH_T  = 6,
  parameter int GAP_T    = 12,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1),
  localparam int FR_W    = MAX_PKTS * PKT_W,
  localparam int LC_W    = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_mcast,
  input  logic [DEST_W-1:0]         in_dest,
  input  logic [PKT_W-1:0]          in_data,
  input  logic [LC_W-1:0]           act_lanes,
  output logic [LANES-1:0]          lo_valid,
  output logic                      lo_mcast,
  output logic [DEST_W-1:0]         lo_dest,
  output logic [SEQ_W-1:0]          lo_seq,
  output logic [CNT_W-1:0]          lo_cnt,
  output logic [FR_W-1:0]           lo_data,
  input  logic [LANES-1:0]          li_valid,
  input  logic [LANES-1:0]          li_mcast,
  input  logic [LANES*DEST_W-1:0]   li_dest,
  input  logic [LANES*SEQ_W-1:0]    li_seq,
  input  logic [LANES*CNT_W-1:0]    li_cnt,
  input  logic [LANES*FR_W-1:0]     li_data,
  output logic                      out_valid,
  output logic [DEST_W-1:0]         out_dest,
  output logic [PKT_W-1:0]          out_data,
  output logic [15:0]               skip_cnt
);
  localparam int LI_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WI_W  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int NDEST = 1 << DEST_W;
  localparam int TM_W  = $clog2(FLUSH_T + 1);
  localparam int GT_W  = $clog2(GAP_T + 1);

  // ingress packer
  logic              open_q;
  logic [DEST_W-1:0] cur_dest;
  logic [CNT_W-1:0]  cur_cnt;
  logic [FR_W-1:0]   cur_data;
  logic [TM_W-1:0]   tmr;
  logic [SEQ_W-1:0]  seq_tab [NDEST];
  logic [LI_W-1:0]   rr, lane_sel, lane_nxt;
  logic [LC_W-1:0]   act_eff;

  wire uni       = in_valid & ~in_mcast;
  wire mc        = in_valid & in_mcast;
  wire close_now = open_q & ((uni & ((in_dest != cur_dest) | (cur_cnt == CNT_W'(MAX_PKTS))))
                           | (~in_valid & (tmr == TM_W'(FLUSH_T))));
  wire start     = uni & (~open_q | close_now);

  always_comb begin
    act_eff = act_lanes;
    if (act_lanes == '0) act_eff = LC_W'(1);
    else if (act_lanes > LC_W'(LANES)) act_eff = LC_W'(LANES);
    lane_sel = (LC_W'(rr) < act_eff) ? rr : '0;
    lane_nxt = (LC_W'(lane_sel) + LC_W'(1) == act_eff) ? '0 : lane_sel + LI_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; cur_dest <= '0; cur_cnt <= '0; cur_data <= '0; tmr <= '0; rr <= '0;
      for (int d = 0; d < NDEST; d++) seq_tab[d] <= '0;
      lo_valid <= '0; lo_mcast <= 1'b0; lo_dest <= '0; lo_seq <= '0; lo_cnt <= '0; lo_data <= '0;
    end else begin
      lo_valid <= '0;
      if (mc | close_now) begin
        lo_valid <= LANES'(1) << lane_sel;
        rr <= lane_nxt;
        if (mc) begin
          lo_mcast <= 1'b1; lo_dest <= in_dest; lo_seq <= '0;
          lo_cnt <= CNT_W'(1); lo_data <= FR_W'(in_data);
        end else begin
          lo_mcast <= 1'b0; lo_dest <= cur_dest; lo_seq <= seq_tab[cur_dest];
          lo_cnt <= cur_cnt; lo_data <= cur_data;
          seq_tab[cur_dest] <= seq_tab[cur_dest] + SEQ_W'(1);
        end
      end
      if (start) begin
        open_q <= 1'b1; cur_dest <= in_dest; cur_cnt <= CNT_W'(1); cur_data <= FR_W'(in_data);
      end else if (uni) begin
        cur_data[int'(cur_cnt)*PKT_W +: PKT_W] <= in_data;
        cur_cnt <= cur_cnt + CNT_W'(1);
      end else if (close_now) begin
        open_q <= 1'b0;
      end
      if (start) tmr <= '0;
      else if (open_q && tmr != TM_W'(FLUSH_T)) tmr <= tmr + TM_W'(1);
    end
  end

  a_r6_lane_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lo_valid));
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (|lo_valid) |-> (lo_cnt >= CNT_W'(1) && lo_cnt <= CNT_W'(MAX_PKTS)));
  a_r5_mcast_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (|lo_valid && lo_mcast) |-> (lo_cnt == CNT_W'(1) && lo_seq == '0));
  a_r7_lane_active: assert property (@(posedge clk) disable iff (!rst_n)
    (|lo_valid) |-> ((lo_valid >> $past(act_eff)) == '0));

  // egress reorderer
  logic              sv   [WIN];
  logic [DEST_W-1:0] sd   [WIN];
  logic [CNT_W-1:0]  sc   [WIN];
  logic [FR_W-1:0]   sdat [WIN];
  logic [SEQ_W-1:0]  exp_q;
  logic [CNT_W-1:0]  idx;
  logic [GT_W-1:0]   gtmr;
  logic              pend;
  logic [LANES-1:0]  acc;
  logic [WI_W-1:0]   lslot [LANES];
  logic [SEQ_W-1:0]  loff  [LANES];

  wire [WI_W-1:0] hslot = exp_q[WI_W-1:0];
  wire head_v    = sv[hslot];
  wire head_last = (idx == sc[hslot] - CNT_W'(1));
  wire skip      = ~head_v & pend & (gtmr == GT_W'(GAP_T - 1));

  always_comb begin
    pend = 1'b0;
    for (int w = 0; w < WIN; w++) pend = pend | sv[w];
    for (int l = 0; l < LANES; l++) begin
      lslot[l] = li_seq[l*SEQ_W +: WI_W];
      loff[l]  = li_seq[l*SEQ_W +: SEQ_W] - exp_q;
      acc[l]   = li_valid[l] & ~li_mcast[l] & (loff[l] < SEQ_W'(WIN)) & ~sv[lslot[l]]
               & ~(skip & (loff[l] == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WIN; w++) begin sv[w] <= 1'b0; sd[w] <= '0; sc[w] <= '0; sdat[w] <= '0; end
      exp_q <= '0; idx <= '0; gtmr <= '0; skip_cnt <= '0;
      out_valid <= 1'b0; out_dest <= '0; out_data <= '0;
    end else begin
      out_valid <= head_v;
      if (head_v) begin
        out_dest <= sd[hslot];
        out_data <= sdat[hslot][int'(idx)*PKT_W +: PKT_W];
        if (head_last) begin
          sv[hslot] <= 1'b0; idx <= '0;
        end else idx <= idx + CNT_W'(1);
      end
      for (int l = 0; l < LANES; l++) if (acc[l]) begin
        sv[lslot[l]]   <= 1'b1;
        sd[lslot[l]]   <= li_dest[l*DEST_W +: DEST_W];
        sc[lslot[l]]   <= li_cnt[l*CNT_W +: CNT_W];
        sdat[lslot[l]] <= li_data[l*FR_W +: FR_W];
      end
      if ((head_v & head_last) | skip) exp_q <= exp_q + SEQ_W'(1);
      if (skip) skip_cnt <= skip_cnt + 16'd1;
      gtmr <= (head_v | ~pend | skip) ? '0 : gtmr + GT_W'(1);
    end
  end

  a_r11_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_cnt != $past(skip_cnt)) |-> (skip_cnt == $past(skip_cnt) + 16'd1));
endmodule

// File: tb/sf_pack_reorder_test.sv
module sf_pack_reorder_test;
  localparam int PKT_W = 8, MAX_PKTS = 4, DEST_W = 2, LANES = 4;
  localparam int SEQ_W = 4, WIN = 4, FLUSH_T = 5, GAP_T = 10;
  localparam int CNT_W = $clog2(MAX_PKTS + 1), FR_W = MAX_PKTS * PKT_W, LC_W = $clog2(LANES + 1);
  localparam int SMOD = 1 << SEQ_W;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_mcast = 0;
  logic [DEST_W-1:0] in_dest = 0;
  logic [PKT_W-1:0] in_data = 0;
  logic [LC_W-1:0] act_lanes = LC_W'(LANES);
  logic [LANES-1:0] lo_valid;
  logic lo_mcast;
  logic [DEST_W-1:0] lo_dest;
  logic [SEQ_W-1:0] lo_seq;
  logic [CNT_W-1:0] lo_cnt;
  logic [FR_W-1:0] lo_data;
  logic [LANES-1:0] li_valid = 0, li_mcast = 0;
  logic [LANES*DEST_W-1:0] li_dest = 0;
  logic [LANES*SEQ_W-1:0] li_seq = 0;
  logic [LANES*CNT_W-1:0] li_cnt = 0;
  logic [LANES*FR_W-1:0] li_data = 0;
  logic out_valid;
  logic [DEST_W-1:0] out_dest;
  logic [PKT_W-1:0] out_data;
  logic [15:0] skip_cnt;

  always #2.5 clk = ~clk;

  sf_pack_reorder #(.PKT_W(PKT_W), .MAX_PKTS(MAX_PKTS), .DEST_W(DEST_W), .LANES(LANES),
    .SEQ_W(SEQ_W), .WIN(WIN), .FLUSH_T(FLUSH_T), .GAP_T(GAP_T)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mcast(in_mcast), .in_dest(in_dest),
    .in_data(in_data), .act_lanes(act_lanes), .lo_valid(lo_valid), .lo_mcast(lo_mcast),
    .lo_dest(lo_dest), .lo_seq(lo_seq), .lo_cnt(lo_cnt), .lo_data(lo_data),
    .li_valid(li_valid), .li_mcast(li_mcast), .li_dest(li_dest), .li_seq(li_seq),
    .li_cnt(li_cnt), .li_data(li_data), .out_valid(out_valid), .out_dest(out_dest),
    .out_data(out_data), .skip_cnt(skip_cnt));

  int vectors = 0, miscompares = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // ingress reference
  int m_seq [1<<DEST_W];
  int m_open, m_dest, m_tmr, m_rr;
  int mpk [$];
  logic [LANES-1:0] e_lv;
  int e_mc, e_dest, e_seq, e_cnt;
  logic [FR_W-1:0] e_data;

  // egress reference
  bit fv [SMOD];
  int fc [SMOD], fd [SMOD];
  logic [FR_W-1:0] fdat [SMOD];
  int m_exp, m_idx, m_gt, m_loss;
  int eo_v, eo_dest, eo_data;

  task automatic send(input int mc, input int d, input int s, input int c, input logic [FR_W-1:0] dat, input int act);
    int lane;
    lane = (m_rr < act) ? m_rr : 0;
    m_rr = (lane + 1 == act) ? 0 : lane + 1;
    e_lv = LANES'(1) << lane;
    e_mc = mc; e_dest = d; e_seq = s; e_cnt = c; e_data = dat;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_seq[i]) m_seq[i] = 0;
      m_open = 0; m_dest = 0; m_tmr = 0; m_rr = 0; mpk.delete();
      e_lv = 0; e_mc = 0; e_dest = 0; e_seq = 0; e_cnt = 0; e_data = 0;
      foreach (fv[i]) begin fv[i] = 0; fc[i] = 0; fd[i] = 0; fdat[i] = 0; end
      m_exp = 0; m_idx = 0; m_gt = 0; m_loss = 0; eo_v = 0; eo_dest = 0; eo_data = 0;
    end else begin
      int act; bit uni, flush, closef, start, head, pend, skip;
      bit occ [SMOD];
      logic [FR_W-1:0] pk;
      act = int'(act_lanes);
      if (act == 0) act = 1;
      if (act > LANES) act = LANES;
      uni = in_valid && !in_mcast;
      flush = m_open != 0 && !in_valid && m_tmr == FLUSH_T;
      closef = m_open != 0 && uni && (int'(in_dest) != m_dest || mpk.size() == MAX_PKTS);
      start = uni && (m_open == 0 || closef);
      e_lv = 0;
      if (in_valid && in_mcast) send(1, int'(in_dest), 0, 1, FR_W'(in_data), act);
      else if (closef || flush) begin
        pk = 0;
        foreach (mpk[i]) pk[i*PKT_W +: PKT_W] = PKT_W'(mpk[i]);
        send(0, m_dest, m_seq[m_dest], mpk.size(), pk, act);
        m_seq[m_dest] = (m_seq[m_dest] + 1) % SMOD;
      end
      if (start) m_tmr = 0;
      else if (m_open != 0 && m_tmr != FLUSH_T) m_tmr++;
      if (start) begin mpk.delete(); mpk.push_back(int'(in_data)); m_open = 1; m_dest = int'(in_dest); end
      else if (uni) mpk.push_back(int'(in_data));
      else if (flush) begin m_open = 0; mpk.delete(); end

      head = fv[m_exp];
      pend = 0;
      foreach (fv[i]) begin pend = pend | fv[i]; occ[i] = fv[i]; end
      skip = !head && pend && m_gt == GAP_T - 1;
      eo_v = head;
      if (head) begin eo_dest = fd[m_exp]; eo_data = int'(fdat[m_exp][m_idx*PKT_W +: PKT_W]); end
      for (int l = 0; l < LANES; l++) begin
        int s, off;
        s = int'(li_seq[l*SEQ_W +: SEQ_W]);
        off = (s - m_exp + SMOD) % SMOD;
        if (li_valid[l] && !li_mcast[l] && off < WIN && !occ[s] && !(skip && off == 0)) begin
          fv[s] = 1; fc[s] = int'(li_cnt[l*CNT_W +: CNT_W]);
          fd[s] = int'(li_dest[l*DEST_W +: DEST_W]); fdat[s] = li_data[l*FR_W +: FR_W];
        end
      end
      if (head) begin
        if (m_idx == fc[m_exp] - 1) begin fv[m_exp] = 0; m_exp = (m_exp + 1) % SMOD; m_idx = 0; end
        else m_idx++;
      end
      if (skip) begin m_exp = (m_exp + 1) % SMOD; m_loss++; end
      if (head || !pend || skip) m_gt = 0; else m_gt++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(lo_valid === e_lv, "R6 R7 lane strobe", 64'(lo_valid), 64'(e_lv));
    if (e_lv != 0) begin
      chk(lo_mcast === e_mc[0], "R5 multicast flag", 64'(lo_mcast), 64'(e_mc));
      chk(int'(lo_dest) == e_dest, "R1 frame destination", 64'(lo_dest), 64'(e_dest));
      chk(int'(lo_seq) == e_seq, "R4 sequence number", 64'(lo_seq), 64'(e_seq));
      chk(int'(lo_cnt) == e_cnt, "R2 R3 packet count", 64'(lo_cnt), 64'(e_cnt));
      chk(lo_data === e_data, "R1 R3 frame payload", 64'(lo_data), 64'(e_data));
    end
    chk(out_valid === eo_v[0], "R8 R10 released valid", 64'(out_valid), 64'(eo_v));
    if (eo_v != 0) begin
      chk(int'(out_data) == eo_data, "R9 released data", 64'(out_data), 64'(eo_data));
      chk(int'(out_dest) == eo_dest, "R9 released destination", 64'(out_dest), 64'(eo_dest));
    end
    chk(int'(skip_cnt) == m_loss, "R11 skip count", 64'(skip_cnt), 64'(m_loss));
  end

  task automatic step();
    @(negedge clk);
    in_valid = 0; in_mcast = 0; li_valid = 0; li_mcast = 0;
  endtask

  task automatic pkt(input int mc, input int d, input int dat);
    in_valid = 1; in_mcast = mc[0]; in_dest = DEST_W'(d); in_data = PKT_W'(dat);
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input int l, input int mc, input int s, input int c);
    li_valid[l] = 1; li_mcast[l] = mc[0];
    li_dest[l*DEST_W +: DEST_W] = DEST_W'($urandom);
    li_seq[l*SEQ_W +: SEQ_W] = SEQ_W'(s);
    li_cnt[l*CNT_W +: CNT_W] = CNT_W'(c);
    li_data[l*FR_W +: FR_W] = FR_W'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(lo_valid == 0 && out_valid == 0 && skip_cnt == 0, "R12 reset state",
        64'({lo_valid, out_valid, skip_cnt}), 64'd0);
    rst_n = 1;
    step();
    // R1 R2: fill beyond size, then R3 flush on idle
    for (int i = 0; i < 9; i++) pkt(0, 1, 16 + i);
    idle(FLUSH_T + 4);
    // R2: destination change closes
    pkt(0, 0, 1); pkt(0, 2, 2); pkt(0, 0, 3); pkt(0, 0, 4);
    // R5: multicast inside an open frame, and on the flush cycle
    pkt(1, 3, 5); pkt(0, 0, 6);
    idle(FLUSH_T);
    pkt(1, 1, 7); pkt(1, 2, 8);
    idle(4);
    // R7: shrinking active lanes
    act_lanes = 3;
    for (int i = 0; i < 8; i++) pkt(1, i % 4, i);
    act_lanes = 1;
    for (int i = 0; i < 3; i++) pkt(1, 0, i);
    act_lanes = 0;
    for (int i = 0; i < 3; i++) pkt(0, i % 4, i);
    act_lanes = 4;
    idle(FLUSH_T + 3);
    // R4: wrap per-destination counters
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 20 == 0) act_lanes = LC_W'($urandom % (LANES + 2));
      if ($urandom % 4 != 0) pkt(($urandom % 6 == 0) ? 1 : 0, $urandom % 3, $urandom);
      else step();
    end
    act_lanes = 4;
    idle(FLUSH_T + 3);
    // R8 R9: out-of-order pair
    put(2, 0, 1, 2); put(0, 0, 0, 3); step();
    idle(8);
    // R8: duplicate while held
    put(1, 0, 2, 1); step(); put(3, 0, 2, 1); step();
    idle(3);
    // R10: multicast with the expected number; R8: beyond window and stale
    put(0, 1, 3, 2); put(1, 0, 7, 2); put(2, 0, 2, 2); step();
    idle(4);
    // R11: two missing numbers
    put(0, 0, 5, 2); step();
    idle(2 * GAP_T + 8);
    // R9: wrap with swapped pairs
    for (int k = 6; k < 46; k += 2) begin
      put(k % 4, 0, (k + 1) % SMOD, 1 + $urandom % 4);
      put((k + 1) % 4, 0, k % SMOD, 1 + $urandom % 4);
      step();
      idle(9);
    end
    for (int i = 0; i < 600; i++) begin
      for (int l = 0; l < LANES; l++)
        if ($urandom % 4 == 0) put(l, ($urandom % 8 == 0) ? 1 : 0, (m_exp + SMOD - 1 + $urandom % 6) % SMOD, 1 + $urandom % 4);
      step();
    end
    idle(3 * GAP_T + 40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule